// File: doc/BRIEF.md
# NAND Read-Retry Command Sequencer

This block sits on the controller side of a raw NAND flash bus. It produces the command-latch, address-latch, write-data and read-data cycle strobes, along with the outgoing byte, for two vendor-private maintenance jobs. The first job is mode programming. It selects one of several read-retry voltage modes by writing a group of hidden device registers between an enter command and an apply command. Each register address is sent twice, once in each byte of a 16-bit column, and is followed by one data byte.

The second job is table fetch. It unlocks a hidden one-time-programmable page, streams the factory read-retry table out of it, and then puts the device back into normal operation. Every reset and every page read is followed by a wait on the ready/busy line. The wait is guarded by a programmable timeout.

The host pulses `start` with an operation select, a mode number and a register count, then waits for the one-cycle `done` pulse. During mode programming the register values come from an external parameter memory through a lookup port. The block only generates bus cycles. Electrical timing, data capture and ECC are handled elsewhere.

Top module: `nrr_seq`

## Requirements
- R1: Mode programming (`op_sel`=0) emits command 0x36. For each register it then emits two address cycles that both carry the register address, followed by one data cycle. It ends with command 0x16. Register i uses the address at position i of the list 0xCC, 0xBF, 0xAA, 0xAB, 0xCD, 0xAD, 0xAE, 0xAF.
- R2: The data byte for register i in mode m is the parameter memory word at index m*n + i, where n is the effective register count. `pm_addr` holds that index for the whole three-cycle group. `pm_data` is sampled on the second address cycle, so the memory may have up to one cycle of read latency.
- R3: With a register count of 0, only the two framing commands are emitted. A count above 8 is treated as 8.
- R4: Table fetch (`op_sel`=1) emits the following, in order:
  - reset 0xFF and a ready wait;
  - 0x36, two address cycles of 0x38, data 0x52, then 0x16;
  - commands 0x17, 0x04, 0x19;
  - command 0x00, two zero column address cycles, three row address cycles (least significant byte first), command 0x30 and a ready wait;
  - one read strobe per table byte.
- R5: With `layout_sel`=0 the table page is 0x21F and the length is 784 bytes. With `layout_sel`=1 the page is 0x200 and the length is 528 bytes.
- R6: After the table bytes, the block emits the following, in order:
  - reset 0xFF and a ready wait;
  - 0x36, two address cycles of 0x38, data 0x00, then 0x16;
  - command 0x00, five zero address cycles, command 0x30 and a ready wait.
  
  It then issues no read strobes, because this dummy read has zero length.
- R7: After 0xFF or 0x30, the block ignores `rdy` for GUARD cycles and then issues no strobe until `rdy` is seen high.
- R8: If `rdy` stays low for `wait_limit` cycles after the guard, the sequence aborts and `done` pulses with `err` high. `err` stays high until the next accepted start.
- R9: `busy` rises the cycle after an accepted start. `done` is a single-cycle pulse, in the first cycle after `busy` falls.
- R10: A `start` pulse that arrives while `busy` is high is ignored. The running sequence is unchanged and only one `done` follows.
- R11: At most one of `cle`, `ale`, `we`, `re` is high in any cycle, and none is high while the block is idle.
- R12: After reset, all strobes, `busy`, `done` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start strobe, sampled while idle |
| op_sel | input | 1 | 0 = program retry mode, 1 = fetch table |
| layout_sel | input | 1 | Table page/length variant |
| mode_sel | input | MODE_W | Retry mode number |
| reg_count | input | CNT_W | Number of registers to write |
| wait_limit | input | TO_W | Ready-wait timeout in cycles |
| pm_addr | output | MODE_W+3 | Parameter memory index |
| pm_data | input | 8 | Parameter memory word |
| cle | output | 1 | Command cycle strobe |
| ale | output | 1 | Address cycle strobe |
| we | output | 1 | Write-data cycle strobe |
| re | output | 1 | Read-data cycle strobe |
| dq_out | output | 8 | Byte for command/address/data cycles |
| rdy | input | 1 | Device ready (high) / busy (low) |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last sequence aborted on timeout |

## Verification
A start request can land in a cycle where the sequencer is already driving a bus cycle for an earlier request. The bench provokes this by pulsing `start` with the opposite operation a few cycles into a running mode-programming sequence. The logged command/address/data trace must still match the first request byte for byte, and exactly one `done` pulse may appear. Ready-wait behaviour is judged by the cycle gap between the reset command and the next strobe, and by a device model that never returns ready.

// File: rtl/nrr_pkg.sv
package nrr_pkg;

    localparam int NREG  = 8;
    localparam int CW    = $clog2(NREG + 1);
    localparam int LEN_W = 10;
    localparam int IDX_W = 6;

    localparam logic [7:0] C_RESET  = 8'hFF;
    localparam logic [7:0] C_ENTER  = 8'h36;
    localparam logic [7:0] C_APPLY  = 8'h16;
    localparam logic [7:0] C_RD_A   = 8'h00;
    localparam logic [7:0] C_RD_B   = 8'h30;
    localparam logic [7:0] C_UNLK0  = 8'h17;
    localparam logic [7:0] C_UNLK1  = 8'h04;
    localparam logic [7:0] C_UNLK2  = 8'h19;
    localparam logic [7:0] R_OTPSEL = 8'h38;
    localparam logic [7:0] V_OTP_ON = 8'h52;
    localparam logic [7:0] V_OTP_OFF = 8'h00;

    localparam logic [23:0]      PAGE_MAIN = 24'h00021F;
    localparam logic [LEN_W-1:0] LEN_MAIN  = LEN_W'(784);
    localparam logic [23:0]      PAGE_ALT  = 24'h000200;
    localparam logic [LEN_W-1:0] LEN_ALT   = LEN_W'(528);

    typedef enum logic [2:0] {
        K_CMD, K_ADDR, K_WDATA, K_WAIT, K_READ, K_REGS, K_END
    } kind_e;

    typedef struct packed {
        kind_e            kind;
        logic [7:0]       val;
        logic [LEN_W-1:0] len;
    } step_t;

    typedef enum logic { S_IDLE, S_RUN } seq_st_e;

    function automatic step_t mk(kind_e k, logic [7:0] v, logic [LEN_W-1:0] l);
        step_t s;
        s.kind = k;
        s.val  = v;
        s.len  = l;
        return s;
    endfunction

    function automatic logic [7:0] retry_reg(logic [CW-1:0] i);
        case (i)
            CW'(0):  return 8'hCC;
            CW'(1):  return 8'hBF;
            CW'(2):  return 8'hAA;
            CW'(3):  return 8'hAB;
            CW'(4):  return 8'hCD;
            CW'(5):  return 8'hAD;
            CW'(6):  return 8'hAE;
            default: return 8'hAF;
        endcase
    endfunction

    function automatic step_t prog_step(logic [IDX_W-1:0] idx);
        case (idx)
            IDX_W'(0): return mk(K_CMD, C_ENTER, '0);
            IDX_W'(1): return mk(K_REGS, 8'h00, '0);
            IDX_W'(2): return mk(K_CMD, C_APPLY, '0);
            default:   return mk(K_END, 8'h00, '0);
        endcase
    endfunction

    function automatic step_t fetch_step(logic [IDX_W-1:0] idx, logic alt);
        logic [23:0]      pg;
        logic [LEN_W-1:0] ln;
        pg = alt ? PAGE_ALT : PAGE_MAIN;
        ln = alt ? LEN_ALT  : LEN_MAIN;
        case (idx)
            IDX_W'(0):  return mk(K_CMD,   C_RESET,   '0);
            IDX_W'(1):  return mk(K_WAIT,  8'h00,     '0);
            IDX_W'(2):  return mk(K_CMD,   C_ENTER,   '0);
            IDX_W'(3):  return mk(K_ADDR,  R_OTPSEL,  '0);
            IDX_W'(4):  return mk(K_ADDR,  R_OTPSEL,  '0);
            IDX_W'(5):  return mk(K_WDATA, V_OTP_ON,  '0);
            IDX_W'(6):  return mk(K_CMD,   C_APPLY,   '0);
            IDX_W'(7):  return mk(K_CMD,   C_UNLK0,   '0);
            IDX_W'(8):  return mk(K_CMD,   C_UNLK1,   '0);
            IDX_W'(9):  return mk(K_CMD,   C_UNLK2,   '0);
            IDX_W'(10): return mk(K_CMD,   C_RD_A,    '0);
            IDX_W'(11): return mk(K_ADDR,  8'h00,     '0);
            IDX_W'(12): return mk(K_ADDR,  8'h00,     '0);
            IDX_W'(13): return mk(K_ADDR,  pg[7:0],   '0);
            IDX_W'(14): return mk(K_ADDR,  pg[15:8],  '0);
            IDX_W'(15): return mk(K_ADDR,  pg[23:16], '0);
            IDX_W'(16): return mk(K_CMD,   C_RD_B,    '0);
            IDX_W'(17): return mk(K_WAIT,  8'h00,     '0);
            IDX_W'(18): return mk(K_READ,  8'h00,     ln);
            IDX_W'(19): return mk(K_CMD,   C_RESET,   '0);
            IDX_W'(20): return mk(K_WAIT,  8'h00,     '0);
            IDX_W'(21): return mk(K_CMD,   C_ENTER,   '0);
            IDX_W'(22): return mk(K_ADDR,  R_OTPSEL,  '0);
            IDX_W'(23): return mk(K_ADDR,  R_OTPSEL,  '0);
            IDX_W'(24): return mk(K_WDATA, V_OTP_OFF, '0);
            IDX_W'(25): return mk(K_CMD,   C_APPLY,   '0);
            IDX_W'(26): return mk(K_CMD,   C_RD_A,    '0);
            IDX_W'(27), IDX_W'(28), IDX_W'(29), IDX_W'(30), IDX_W'(31):
                        return mk(K_ADDR,  8'h00,     '0);
            IDX_W'(32): return mk(K_CMD,   C_RD_B,    '0);
            IDX_W'(33): return mk(K_WAIT,  8'h00,     '0);
            IDX_W'(34): return mk(K_READ,  8'h00,     '0);
            default:    return mk(K_END,   8'h00,     '0);
        endcase
    endfunction

endpackage

// File: rtl/nrr_reg_walker.sv
module nrr_reg_walker
    import nrr_pkg::*;
#(
    parameter int MODE_W = 3,
    localparam int PM_AW = MODE_W + $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic [MODE_W-1:0] mode,
    input  logic [CW-1:0]     count,
    input  logic [7:0]        pm_data,
    output logic [PM_AW-1:0]  pm_addr,
    output logic              addr_stb,
    output logic              data_stb,
    output logic [7:0]        byte_out,
    output logic              last
);
    logic [CW-1:0] ri_q;
    logic [1:0]    ph_q;
    logic [7:0]    val_q;
    logic          nonempty;

    assign nonempty = (count != '0);

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            ri_q <= '0;
            ph_q <= '0;
            if (rst) val_q <= '0;
        end else begin
            if (ph_q == 2'd1) val_q <= pm_data;
            if (ph_q == 2'd2) begin
                ph_q <= '0;
                ri_q <= ri_q + 1'b1;
            end else begin
                ph_q <= ph_q + 1'b1;
            end
        end
    end

    assign pm_addr  = PM_AW'(mode) * PM_AW'(count) + PM_AW'(ri_q);
    assign addr_stb = active && nonempty && (ph_q != 2'd2);
    assign data_stb = active && nonempty && (ph_q == 2'd2);
    assign byte_out = (ph_q == 2'd2) ? val_q : retry_reg(ri_q);
    assign last     = active && (!nonempty || ((ph_q == 2'd2) && (ri_q == count - 1'b1)));
endmodule

// File: rtl/nrr_wait_timer.sv
module nrr_wait_timer #(
    parameter int GUARD = 2,
    parameter int TO_W  = 16,
    localparam int G_W  = $clog2(GUARD + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            active,
    input  logic            rdy,
    input  logic [TO_W-1:0] limit,
    output logic            ok,
    output logic            expired
);
    logic [G_W-1:0]  g_q;
    logic [TO_W-1:0] t_q;
    logic            armed;

    assign armed = (g_q == G_W'(GUARD));

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            g_q <= '0;
            t_q <= '0;
        end else if (!armed) begin
            g_q <= g_q + 1'b1;
        end else if (t_q != '1) begin
            t_q <= t_q + 1'b1;
        end
    end

    assign ok      = active && armed && rdy;
    assign expired = active && armed && !rdy && (t_q >= limit);
endmodule

// File: rtl/nrr_stream.sv
module nrr_stream
    import nrr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic [LEN_W-1:0] len,
    output logic             strobe,
    output logic             fin
);
    logic [LEN_W-1:0] n_q;

    always_ff @(posedge clk) begin
        if (rst || !active) n_q <= '0;
        else if (strobe)    n_q <= n_q + 1'b1;
    end

    assign strobe = active && (n_q < len);
    assign fin    = active && ((len == '0) || (n_q == len - 1'b1));
endmodule

// File: rtl/nrr_seq.sv
module nrr_seq
    import nrr_pkg::*;
#(
    parameter int MODE_W = 3,
    parameter int CNT_W  = 4,
    parameter int TO_W   = 16,
    parameter int GUARD  = 2,
    localparam int PM_AW = MODE_W + $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              op_sel,
    input  logic              layout_sel,
    input  logic [MODE_W-1:0] mode_sel,
    input  logic [CNT_W-1:0]  reg_count,
    input  logic [TO_W-1:0]   wait_limit,
    output logic [PM_AW-1:0]  pm_addr,
    input  logic [7:0]        pm_data,
    output logic              cle,
    output logic              ale,
    output logic              we,
    output logic              re,
    output logic [7:0]        dq_out,
    input  logic              rdy,
    output logic              busy,
    output logic              done,
    output logic              err
);
    seq_st_e           st_q;
    logic [IDX_W-1:0]  idx_q;
    logic              op_q, alt_q, done_q, err_q;
    logic [MODE_W-1:0] mode_q;
    logic [CW-1:0]     cnt_q;
    logic [TO_W-1:0]   lim_q;
    step_t             cur;
    logic              run;
    logic              w_addr, w_data, w_last;
    logic [7:0]        w_byte;
    logic              t_ok, t_exp;
    logic              s_stb, s_fin;
    logic              adv;
    logic [CW-1:0]     cnt_clamped;

    assign run = (st_q == S_RUN);
    assign cur = op_q ? fetch_step(idx_q, alt_q) : prog_step(idx_q);
    assign cnt_clamped = (reg_count > CNT_W'(NREG)) ? CW'(NREG) : CW'(reg_count);

    nrr_reg_walker #(.MODE_W(MODE_W)) u_walk (
        .clk(clk), .rst(rst),
        .active(run && cur.kind == K_REGS),
        .mode(mode_q), .count(cnt_q), .pm_data(pm_data),
        .pm_addr(pm_addr), .addr_stb(w_addr), .data_stb(w_data),
        .byte_out(w_byte), .last(w_last)
    );

    nrr_wait_timer #(.GUARD(GUARD), .TO_W(TO_W)) u_wait (
        .clk(clk), .rst(rst),
        .active(run && cur.kind == K_WAIT),
        .rdy(rdy), .limit(lim_q), .ok(t_ok), .expired(t_exp)
    );

    nrr_stream u_stream (
        .clk(clk), .rst(rst),
        .active(run && cur.kind == K_READ),
        .len(cur.len), .strobe(s_stb), .fin(s_fin)
    );

    always_comb begin
        case (cur.kind)
            K_CMD, K_ADDR, K_WDATA: adv = 1'b1;
            K_REGS:                 adv = w_last;
            K_WAIT:                 adv = t_ok;
            K_READ:                 adv = s_fin;
            default:                adv = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= S_IDLE;
            idx_q  <= '0;
            op_q   <= 1'b0;
            alt_q  <= 1'b0;
            mode_q <= '0;
            cnt_q  <= '0;
            lim_q  <= '0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st_q)
                S_IDLE: if (start) begin
                    st_q   <= S_RUN;
                    idx_q  <= '0;
                    op_q   <= op_sel;
                    alt_q  <= layout_sel;
                    mode_q <= mode_sel;
                    cnt_q  <= cnt_clamped;
                    lim_q  <= wait_limit;
                    err_q  <= 1'b0;
                end
                default: begin
                    if (cur.kind == K_END) begin
                        st_q   <= S_IDLE;
                        done_q <= 1'b1;
                    end else if (cur.kind == K_WAIT && t_exp && !t_ok) begin
                        st_q   <= S_IDLE;
                        done_q <= 1'b1;
                        err_q  <= 1'b1;
                    end else if (adv) begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
            endcase
        end
    end

    always_comb begin
        cle    = 1'b0;
        ale    = 1'b0;
        we     = 1'b0;
        re     = 1'b0;
        dq_out = 8'h00;
        if (run) begin
            case (cur.kind)
                K_CMD:   begin cle = 1'b1; dq_out = cur.val; end
                K_ADDR:  begin ale = 1'b1; dq_out = cur.val; end
                K_WDATA: begin we  = 1'b1; dq_out = cur.val; end
                K_REGS:  begin
                    ale = w_addr;
                    we  = w_data;
                    if (w_addr || w_data) dq_out = w_byte;
                end
                K_READ:  re = s_stb;
                default: ;
            endcase
        end
    end

    assign busy = run;
    assign done = done_q;
    assign err  = err_q;
endmodule

// File: rtl/nrr_seq_chk.sv
module nrr_seq_chk (
    input logic clk,
    input logic rst,
    input logic start,
    input logic busy,
    input logic done,
    input logic err,
    input logic cle,
    input logic ale,
    input logic we,
    input logic re
);
    assert_strobe_onehot_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cle, ale, we, re}));

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !(cle || ale || we || re));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_after_busy_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    assert_err_with_done_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> done);

    assert_wdata_after_addr_R1: assert property (@(posedge clk) disable iff (rst)
        we |-> $past(ale));

    assert_start_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> (busy || done));
endmodule

bind nrr_seq nrr_seq_chk u_chk (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done), .err(err),
    .cle(cle), .ale(ale), .we(we), .re(re)
);

// File: tb/nrr_seq_bench.sv
module nrr_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int BUSY_CYC   = 5;
    localparam int LIMIT      = 20;
    localparam int MAXEV      = 64;

    typedef struct packed {
        logic       op;
        logic       alt;
        logic [2:0] mode;
        logic [3:0] cnt;
        logic [9:0] reads;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b0, 1'b0, 3'd0, 4'd8,  10'd0},
        '{1'b0, 1'b0, 3'd5, 4'd3,  10'd0},
        '{1'b0, 1'b0, 3'd7, 4'd0,  10'd0},
        '{1'b0, 1'b0, 3'd2, 4'd12, 10'd0},
        '{1'b1, 1'b0, 3'd0, 4'd0,  10'd784},
        '{1'b1, 1'b1, 3'd0, 4'd0,  10'd528}
    };

    logic clk = 1'b0, rst = 1'b1;
    logic start = 1'b0, op_sel = 1'b0, layout_sel = 1'b0;
    logic [2:0]  mode_sel = '0;
    logic [3:0]  reg_count = '0;
    logic [15:0] wait_limit = 16'(LIMIT);
    logic [5:0]  pm_addr;
    logic [7:0]  pm_data;
    logic cle, ale, we, re, busy, done, err;
    logic [7:0] dq_out;
    logic rdy = 1'b1;

    int total = 0, fails = 0, cyc = 0;
    int n_ev = 0, rd_cnt = 0, done_cnt = 0, overlap = 0, busy_left = 0;
    bit stuck = 1'b0;
    int ev_k [MAXEV];
    int ev_b [MAXEV];
    int ev_t [MAXEV];
    int x_k  [MAXEV];
    int x_b  [MAXEV];
    int n_x = 0;

    function automatic logic [7:0] pmf(int x);
        return 8'((x * 37 + 91) & 255);
    endfunction

    function automatic int regaddr(int i);
        case (i)
            0: return 'hCC; 1: return 'hBF; 2: return 'hAA; 3: return 'hAB;
            4: return 'hCD; 5: return 'hAD; 6: return 'hAE; default: return 'hAF;
        endcase
    endfunction

    assign pm_data = pmf(int'(pm_addr));

    always #(CLK_PERIOD/2) clk = ~clk;

    nrr_seq u_nrr_seq (
        .clk(clk), .rst(rst), .start(start), .op_sel(op_sel), .layout_sel(layout_sel),
        .mode_sel(mode_sel), .reg_count(reg_count), .wait_limit(wait_limit),
        .pm_addr(pm_addr), .pm_data(pm_data),
        .cle(cle), .ale(ale), .we(we), .re(re), .dq_out(dq_out), .rdy(rdy),
        .busy(busy), .done(done), .err(err)
    );

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            total++;
            $display("FAIL R9 watchdog expired: actual %0d expected %0d", cyc, 150000);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    // Bus logger and device model
    always @(negedge clk) begin
        if (!rst) begin
            if ((int'(cle) + int'(ale) + int'(we) + int'(re)) > 1) overlap++;
            if ((cle || ale || we) && n_ev < MAXEV) begin
                ev_k[n_ev] = cle ? 0 : (ale ? 1 : 2);
                ev_b[n_ev] = int'(dq_out);
                ev_t[n_ev] = cyc;
                n_ev++;
            end
            if (re) rd_cnt++;
            if (done) done_cnt++;
            if (cle && (dq_out == 8'hFF || dq_out == 8'h30)) busy_left = BUSY_CYC;
            else if (busy_left > 0) busy_left--;
            rdy = !stuck && (busy_left == 0);
        end
    end

    task automatic push(int k, int b);
        x_k[n_x] = k;
        x_b[n_x] = b;
        n_x++;
    endtask

    task automatic build_exp(bit op, bit alt, int mode, int cnt);
        int ce;
        n_x = 0;
        if (!op) begin
            ce = (cnt > 8) ? 8 : cnt;
            push(0, 'h36);
            for (int i = 0; i < ce; i++) begin
                push(1, regaddr(i));
                push(1, regaddr(i));
                push(2, int'(pmf(mode * ce + i)));
            end
            push(0, 'h16);
        end else begin
            push(0, 'hFF); push(0, 'h36); push(1, 'h38); push(1, 'h38); push(2, 'h52);
            push(0, 'h16); push(0, 'h17); push(0, 'h04); push(0, 'h19);
            push(0, 'h00); push(1, 0); push(1, 0);
            push(1, alt ? 'h00 : 'h1F); push(1, 'h02); push(1, 0);
            push(0, 'h30);
            push(0, 'hFF); push(0, 'h36); push(1, 'h38); push(1, 'h38); push(2, 'h00);
            push(0, 'h16); push(0, 'h00);
            for (int i = 0; i < 5; i++) push(1, 0);
            push(0, 'h30);
        end
    endtask

    task automatic run_op(bit op, bit alt, int mode, int cnt, bit poke);
        int w;
        @(negedge clk);
        op_sel = op; layout_sel = alt; mode_sel = 3'(mode); reg_count = 4'(cnt);
        n_ev = 0; rd_cnt = 0; done_cnt = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1, "R9", "busy after start", int'(busy), 1);
        if (poke) begin
            repeat (3) @(negedge clk);
            op_sel = ~op; reg_count = 4'd1; mode_sel = 3'd6;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        w = 0;
        while (done !== 1'b1 && w < 5000) begin
            @(negedge clk);
            w++;
        end
        chk(w < 5000, "R9", "done seen", w, 0);
        chk(busy === 1'b0, "R9", "busy low with done", int'(busy), 0);
        repeat (4) @(negedge clk);
        chk(done_cnt == 1, poke ? "R10" : "R9", "done pulses", done_cnt, 1);
    endtask

    task automatic cmp_trace(bit op, bit alt, int cnt);
        string tg;
        int lim;
        if (!op) tg = (cnt == 0 || cnt > 8) ? "R3" : "R1";
        else     tg = alt ? "R5" : "R4";
        chk(n_ev == n_x, tg, "event count", n_ev, n_x);
        lim = (n_ev < n_x) ? n_ev : n_x;
        for (int i = 0; i < lim; i++) begin
            string t2;
            t2 = tg;
            if (!op && x_k[i] == 2) t2 = "R2";
            if (op && i >= 16) t2 = "R6";
            chk(ev_k[i] == x_k[i], t2, $sformatf("event %0d kind", i), ev_k[i], x_k[i]);
            chk(ev_b[i] == x_b[i], t2, $sformatf("event %0d byte", i), ev_b[i], x_b[i]);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12: reset state
        chk({cle, ale, we, re, busy, done, err} == 7'b0, "R12", "outputs after reset",
            int'({cle, ale, we, re, busy, done, err}), 0);

        foreach (VECS[v]) begin
            run_op(VECS[v].op, VECS[v].alt, int'(VECS[v].mode), int'(VECS[v].cnt), 1'b0);
            build_exp(VECS[v].op, VECS[v].alt, int'(VECS[v].mode), int'(VECS[v].cnt));
            cmp_trace(VECS[v].op, VECS[v].alt, int'(VECS[v].cnt));
            chk(rd_cnt == int'(VECS[v].reads), VECS[v].alt ? "R5" : "R4",
                "read strobes", rd_cnt, int'(VECS[v].reads));
            chk(err === 1'b0, "R8", "err clear on normal run", int'(err), 0);
            if (VECS[v].op && n_ev > 1)
                // R7: nothing issued before ready returns after the reset command
                chk(ev_t[1] - ev_t[0] > BUSY_CYC, "R7", "gap after reset cmd",
                    ev_t[1] - ev_t[0], BUSY_CYC + 1);
        end

        // R10: start while busy is ignored
        run_op(1'b0, 1'b0, 4, 5, 1'b1);
        build_exp(1'b0, 1'b0, 4, 5);
        cmp_trace(1'b0, 1'b0, 5);

        // R8: ready never returns
        stuck = 1'b1;
        run_op(1'b1, 1'b0, 0, 0, 1'b0);
        chk(err === 1'b1, "R8", "err on timeout", int'(err), 1);
        chk(n_ev == 1, "R8", "events before abort", n_ev, 1);
        chk(rd_cnt == 0, "R8", "no reads after abort", rd_cnt, 0);
        stuck = 1'b0;
        repeat (BUSY_CYC + 2) @(negedge clk);
        run_op(1'b0, 1'b0, 1, 2, 1'b0);
        chk(err === 1'b0, "R8", "err cleared by next start", int'(err), 0);

        chk(overlap == 0, "R11", "overlapping strobes", overlap, 0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule